// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the peripheral clock into a single-cycle tick at sixteen times the serial bit rate. A receiver or transmitter counts sixteen of these ticks per bit. The tick rate comes from two stages. The first is a 16-bit integer divisor, held as a low byte and a high byte. The second is a fractional stage that lengthens some tick periods, so that the average division ratio can take a value that no whole number gives.

The fractional stage is set by one byte that holds two 4-bit values: an addend and a modulus. On every tick, an accumulator adds the addend. When the sum reaches the modulus, the modulus is subtracted and the following tick period is doubled. The average period is therefore the divisor times (1 + addend/modulus). For example, a 60 MHz clock with a divisor of 366, an addend of 1 and a modulus of 15 gives a tick rate close to 16 × 9600.

A host reaches four byte registers through a simple write strobe and a combinational read port. The divisor bytes are reachable only while the access bit of the control register is set. Any accepted write to a divisor byte or to the fractional byte restarts the period counter and the accumulator, so the very next tick already follows the new setting.

Top module: `fbg_baud_gen`

## Requirements
- R1: After reset, the divisor reads 0x0001, the fractional byte reads 0x10 (modulus 1, addend 0) and the control register reads 0x00. The tick output is high on every cycle.
- R2: The register addresses are: 0 = divisor low byte, 1 = divisor high byte, 2 = fractional byte (bits 3:0 addend, bits 7:4 modulus), 3 = control (bit 7 = divisor access). `reg_rdata` follows `reg_addr` combinationally.
- R3: While control bit 7 is 0, writes to addresses 0 and 1 are ignored: they neither change the divisor nor disturb the tick phase. Reads of those addresses return 0x00 in that state.
- R4: When the addend is 0, `tick_os` is a one-cycle pulse every D cycles, where D = {high byte, low byte}.
- R5: A divisor of 0 behaves as a divisor of 1: a tick on every cycle, with no lockup.
- R6: When 0 < addend < modulus, tick j (counted from 1 after a restart) comes D·(1 + ⌊(j−1)·A/M⌋ − ⌊(j−2)·A/M⌋) cycles after tick j−1. Tick 1 comes D cycles after the restart.
- R7: A modulus of 0 behaves as a modulus of 1. An addend that is 0, or that is not smaller than the effective modulus, disables the stretching, so that every period is D.
- R8: Every accepted write to address 0 or 1 (with access set), and every write to address 2 (whatever the access bit), restarts the generator. The first tick after the write edge then comes exactly D cycles later. Writes to address 3 do not restart it.
- R9: With the fractional stage active, ticks 2 to M+1 together span exactly D·(M + A) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tick_os | output | 1 | Oversampling tick, one cycle wide |

## Verification
The bound checker watches the following on every cycle: divisor writes are locked out while access is cleared, the divisor bytes read back as zero in that state, a stretched tick is never followed by a tick on the next cycle, and no carry from the accumulator occurs while the fractional stage is inactive. It also checks that the gap between ticks never exceeds twice the effective divisor, and that the first cycle after a restart ticks only for a unit divisor. Only the bench's scenarios can show the exact period sequence the floor formula predicts, and the sum over one full modulus cycle. They also show that an ignored write leaves the tick phase intact and that a restart in the middle of a period realigns the tick.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  localparam int unsigned REG_W      = 8;
  localparam int unsigned ADDR_W     = 2;
  localparam int unsigned DIV_BYTES  = 2;
  localparam int unsigned DIV_W      = DIV_BYTES * REG_W;
  localparam int unsigned FRAC_W     = REG_W / 2;
  localparam int unsigned CNT_W      = DIV_W + 1;
  localparam int unsigned ACCESS_BIT = REG_W - 1;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIV_LO = 2'd0,
    RA_DIV_HI = 2'd1,
    RA_FRAC   = 2'd2,
    RA_CTRL   = 2'd3
  } reg_addr_e;

  // Field order matches the byte layout: modulus high nibble, addend low nibble
  typedef struct packed {
    logic [FRAC_W-1:0] mul;
    logic [FRAC_W-1:0] add;
  } frac_cfg_t;

  localparam frac_cfg_t FRAC_RESET = '{mul: FRAC_W'(1), add: '0};

  // Zero divisor is replaced by one so the counter always terminates
  function automatic logic [DIV_W-1:0] fbg_eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  // Zero modulus is replaced by one
  function automatic logic [FRAC_W-1:0] fbg_eff_mul(input logic [FRAC_W-1:0] m);
    return (m == '0) ? FRAC_W'(1) : m;
  endfunction

  // Stretching only applies for a proper fraction addend/modulus
  function automatic logic fbg_frac_on(input logic [FRAC_W-1:0] a,
                                       input logic [FRAC_W-1:0] m_eff);
    return (a != '0) && (a < m_eff);
  endfunction

  // Length in cycles of one tick period
  function automatic logic [CNT_W-1:0] fbg_period(input logic [DIV_W-1:0] d_eff,
                                                  input logic stretch);
    return stretch ? {d_eff, 1'b0} : {1'b0, d_eff};
  endfunction

endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import fbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [DIV_W-1:0]  div_raw,
  output frac_cfg_t         frac_cfg,
  output logic              access,
  output logic              restart
);

  reg_addr_e ra;
  logic      div_wr_ok;
  logic      frac_wr;

  assign ra        = reg_addr_e'(addr);
  assign div_wr_ok = wr && access && (ra == RA_DIV_LO || ra == RA_DIV_HI);
  assign frac_wr   = wr && (ra == RA_FRAC);
  assign restart   = div_wr_ok || frac_wr;

  // Divisor bytes, one register per byte lane
  for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div_byte
    localparam logic [REG_W-1:0] RST_VAL = (b == 0) ? REG_W'(1) : '0;
    logic [REG_W-1:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= RST_VAL;
      end else if (wr && access && (addr == ADDR_W'(b))) begin
        byte_q <= wdata;
      end
    end
    assign div_raw[b*REG_W +: REG_W] = byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_cfg <= FRAC_RESET;
    end else if (frac_wr) begin
      frac_cfg <= frac_cfg_t'(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      access <= 1'b0;
    end else if (wr && ra == RA_CTRL) begin
      access <= wdata[ACCESS_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (ra)
      RA_DIV_LO: rdata = access ? div_raw[REG_W-1:0] : '0;
      RA_DIV_HI: rdata = access ? div_raw[DIV_W-1:REG_W] : '0;
      RA_FRAC:   rdata = frac_cfg;
      RA_CTRL:   rdata[ACCESS_BIT] = access;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/fbg_int_div.sv
module fbg_int_div
  import fbg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_eff,
  input  logic             stretch,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period;

  assign period = fbg_period(div_eff, stretch);
  assign tick   = (cnt_q == period - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/fbg_frac_acc.sv
module fbg_frac_acc
  import fbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              tick,
  input  logic [FRAC_W-1:0] add,
  input  logic [FRAC_W-1:0] mul_eff,
  output logic              stretch,
  output logic              carry
);

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;
  logic              active;

  assign active = fbg_frac_on(add, mul_eff);
  assign sum    = {1'b0, acc_q} + {1'b0, add};
  assign carry  = tick && active && (sum >= {1'b0, mul_eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      stretch <= 1'b0;
    end else if (restart) begin
      acc_q   <= '0;
      stretch <= 1'b0;
    end else if (tick) begin
      if (!active) begin
        acc_q   <= '0;
        stretch <= 1'b0;
      end else if (carry) begin
        acc_q   <= FRAC_W'(sum - {1'b0, mul_eff});
        stretch <= 1'b1;
      end else begin
        acc_q   <= FRAC_W'(sum);
        stretch <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fbg_baud_gen.sv
module fbg_baud_gen
  import fbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              tick_os
);

  logic [DIV_W-1:0]  div_raw;
  logic [DIV_W-1:0]  div_eff;
  frac_cfg_t         frac_cfg;
  logic [FRAC_W-1:0] mul_eff;
  logic              access;
  logic              restart;
  logic              stretch;
  logic              carry;
  logic              tick;

  assign div_eff = fbg_eff_div(div_raw);
  assign mul_eff = fbg_eff_mul(frac_cfg.mul);
  assign tick_os = tick;

  fbg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .div_raw  (div_raw),
    .frac_cfg (frac_cfg),
    .access   (access),
    .restart  (restart)
  );

  fbg_int_div u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .div_eff (div_eff),
    .stretch (stretch),
    .tick    (tick)
  );

  fbg_frac_acc u_frac (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (tick),
    .add     (frac_cfg.add),
    .mul_eff (mul_eff),
    .stretch (stretch),
    .carry   (carry)
  );

endmodule

// File: rtl/fbg_baud_gen_chk.sv
module fbg_baud_gen_chk
  import fbg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              tick,
  input logic              restart,
  input logic              access,
  input logic              carry,
  input logic [DIV_W-1:0]  div_raw,
  input logic [REG_W-1:0]  frac_byte
);

  logic [CNT_W-1:0]  gap_q;
  logic [DIV_W-1:0]  d_chk;
  logic [FRAC_W-1:0] a_chk;
  logic [FRAC_W-1:0] m_chk;
  logic              stretch_allowed;

  assign d_chk           = (div_raw == '0) ? DIV_W'(1) : div_raw;
  assign a_chk           = frac_byte[FRAC_W-1:0];
  assign m_chk           = (frac_byte[REG_W-1:FRAC_W] == '0) ? FRAC_W'(1)
                                                             : frac_byte[REG_W-1:FRAC_W];
  assign stretch_allowed = (a_chk != '0) && (a_chk < m_chk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= '0;
    else if (tick || restart)  gap_q <= '0;
    else                       gap_q <= gap_q + CNT_W'(1);
  end

  // R3
  div_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !access && reg_addr < ADDR_W'(2)) |=> $stable(div_raw));

  // R3
  div_read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!access && reg_addr < ADDR_W'(2)) |-> (reg_rdata == '0));

  // R6
  stretch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && carry && !restart) |=> !tick);

  // R7
  no_frac_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stretch_allowed |-> !carry);

  // R5
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q < {d_chk, 1'b0});

  // R8
  restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tick == (d_chk == DIV_W'(1))));

endmodule

bind fbg_baud_gen fbg_baud_gen_chk u_fbg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .tick      (tick),
  .restart   (restart),
  .access    (access),
  .carry     (carry),
  .div_raw   (div_raw),
  .frac_byte (frac_cfg)
);

// File: tb/fbg_baud_gen_bench.sv
`timescale 1ns/1ps
module fbg_baud_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       tick_os;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fbg_baud_gen u_fbg_baud_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tick_os   (tick_os)
  );

  // {divisor high, divisor low, fractional byte, tick count}
  localparam int NVEC = 8;
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h00, 8'h03, 8'h10, 8'd8},   // R4 integer only
    {8'h00, 8'h04, 8'h31, 8'd16},  // R6 1/3
    {8'h00, 8'h05, 8'h52, 8'd16},  // R6 2/5
    {8'h01, 8'h6E, 8'hF1, 8'd16},  // R6 R9 1/15 with 366
    {8'h00, 8'h07, 8'h03, 8'd8},   // R7 zero modulus
    {8'h00, 8'h02, 8'h44, 8'd8},   // R7 addend equals modulus
    {8'h00, 8'h00, 8'h10, 8'd8},   // R5 zero divisor
    {8'h00, 8'h06, 8'h76, 8'd16}   // R6 6/7
  };

  function automatic int exp_period(int d, int a, int m, int j);
    int de = (d == 0) ? 1 : d;
    int me = (m == 0) ? 1 : m;
    if (j == 1 || a == 0 || a >= me) return de;
    return de * (1 + ((j - 1) * a) / me - ((j - 2) * a) / me);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called on a falling edge; returns on the falling edge after the write edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  // Cycles from now (counting this falling edge as 1) to the next tick
  task automatic next_gap(output int p);
    int c = 0;
    p = -1;
    for (int k = 0; k < 200000; k++) begin
      c++;
      if (tick_os) begin p = c; break; end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic configure(input int hi, input int lo, input int fr);
    wr(2'd3, 8'h80);
    wr(2'd0, lo[7:0]);
    wr(2'd1, hi[7:0]);
    wr(2'd3, 8'h00);
    wr(2'd2, fr[7:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    int p;
    int per [0:31];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd3, v); check(v == 0, "R1 ctrl", v, 0);
    rd(2'd0, v); check(v == 0, "R3 masked low read", v, 0);
    check(tick_os == 1'b1, "R1 tick every cycle", tick_os, 1);
    @(negedge clk);
    check(tick_os == 1'b1, "R1 tick every cycle", tick_os, 1);
    wr(2'd3, 8'h80);
    rd(2'd0, v); check(v == 1, "R1 R2 divisor low", v, 1);
    rd(2'd1, v); check(v == 0, "R1 R2 divisor high", v, 0);
    rd(2'd2, v); check(v == 8'h10, "R1 R2 frac byte", v, 8'h10);
    rd(2'd3, v); check(v == 8'h80, "R2 ctrl access", v, 8'h80);
    wr(2'd3, 8'h00);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      int hi = int'(VEC[i][31:24]);
      int lo = int'(VEC[i][23:16]);
      int fr = int'(VEC[i][15:8]);
      int n  = int'(VEC[i][7:0]);
      int d  = hi * 256 + lo;
      int a  = fr % 16;
      int m  = fr / 16;
      int sum = 0;
      configure(hi, lo, fr);
      for (int j = 1; j <= n; j++) begin
        next_gap(p);
        per[j] = p;
        check(p == exp_period(d, a, m, j), "R4 R5 R6 R7 R8 period", p, exp_period(d, a, m, j));
      end
      if (a != 0 && m != 0 && a < m && n >= m + 1) begin
        for (int j = 2; j <= m + 1; j++) sum += per[j];
        check(sum == d * (m + a), "R9 modulus cycle sum", sum, d * (m + a));
      end
    end

    // R3 ignored divisor writes keep value and phase
    configure(0, 3, 8'h10);
    wr(2'd0, 8'h09);
    wr(2'd1, 8'h05);
    rd(2'd0, v); check(v == 0, "R3 masked read", v, 0);
    next_gap(p);
    next_gap(p); check(p == 3, "R3 period unchanged", p, 3);
    wr(2'd3, 8'h80);
    rd(2'd0, v); check(v == 3, "R3 low kept", v, 3);
    rd(2'd1, v); check(v == 0, "R3 high kept", v, 0);
    wr(2'd3, 8'h00);

    // R8 restart in mid period, frac write with access cleared
    configure(0, 5, 8'h10);
    next_gap(p);
    @(negedge clk);
    wr(2'd2, 8'h10);
    next_gap(p); check(p == 5, "R8 restart realigns", p, 5);
    // R8 control write does not restart: phase stays on the 5-grid
    @(negedge clk);
    wr(2'd3, 8'h00);
    next_gap(p); check(p == 3, "R8 ctrl write no restart", p, 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule